// File: doc/BRIEF.md
# Scrolling Background Tile Fetcher

This block drives the background side of a tile-based raster video generator, advancing one dot per clock. From the dot and line counters it decides, on each clock, which video memory access to issue: a nametable byte that names the tile, an attribute byte that picks its palette, or one of the two pattern planes that hold its pixels. The read port has one cycle of latency. Each completed tile is handed to a downstream pixel shifter as a registered bundle with a one-cycle valid strobe.

The block also owns the 15-bit scroll register. This register packs coarse X in bits 4:0, coarse Y in bits 9:5, the horizontal nametable select in bit 10, the vertical nametable select in bit 11 and fine Y in bits 14:12. The block steps the register in place as rendering moves along the line and down the frame. At fixed dots it refreshes parts of the register from a temporary register, and a simple load port writes the temporary register. No fetch and no scroll update happen when rendering is off or the line is in vertical blank.

Top module: `bg_tile_fetcher`

## Requirements
- R1: While synchronous reset is high, the scroll register, the temporary register, every fetch latch and `tile_valid` clear to zero. After reset, `scroll_q` reads 0 and `tile_valid` reads 0.
- R2: Within each group of eight dots, the low three dot bits select the slot. Slot 0 drives the nametable address, which is 0x2000 OR `scroll_q[11:0]`. `vram_rd` is high only in the slots that drive an address (0, 2, 4, 6).
- R3: Slot 2 drives the attribute address. It is 0x23C0 OR `scroll_q[11:10]` placed at bits 11:10, OR `scroll_q[9:7]` placed at bits 5:3, OR `scroll_q[4:2]` placed at bits 2:0.
- R4: The 2-bit tile attribute is bits 1:0 of the attribute byte after a right shift by 4×`scroll_q[6]` + 2×`scroll_q[1]`.
- R5: Slot 4 drives the low-plane address and slot 6 the high-plane address. The address is 0x1000×`pat_base_sel` OR tile×16 OR plane×8 (plane 0 for low, 1 for high) OR `scroll_q[14:12]`. The tile number is the byte read from the nametable.
- R6: After the high-plane read of every full tile other than the one ending at dot 255, coarse X increments. If coarse X was 31, it becomes 0 and bit 10 toggles.
- R7: At dot 255 a vertical step replaces the coarse X step. Fine Y increments if below 7. Otherwise fine Y clears and coarse Y changes: 29 goes to 0 and toggles bit 11, 31 goes to 0 with bit 11 unchanged, and any other value increments.
- R8: At dot 256, bits under mask 0x041F are copied from the temporary register into the scroll register.
- R9: On the pre-render line (261), at dots 279 to 303, bits under mask 0x7BE0 are copied from the temporary register. On visible lines no such copy takes place.
- R10: Dots 0–255 and 320–335 do full tile fetches. Dots 256–319 drive only nametable and attribute addresses. Dots 336–339 issue two nametable fetches, at dots 336 and 338. Dot 340 is idle with `vram_rd` low.
- R11: With `render_en` low, or on lines 240–260, `vram_rd` stays low, `tile_valid` stays low and `scroll_q` holds its value.
- R12: One cycle after each full tile's high-plane read, `tile_valid` is high for exactly one cycle. In that cycle `tile_num`, `tile_attr`, `tile_lo` and `tile_hi` hold that tile's bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| dot | input | 9 | Dot counter within the line, 0 to 340 |
| line | input | 9 | Line counter, 0 to 261 |
| render_en | input | 1 | High when background or sprite rendering is on |
| pat_base_sel | input | 1 | Selects the pattern table at 0x0000 or 0x1000 |
| tmp_wr_en | input | 1 | Loads the temporary scroll register |
| tmp_wr_data | input | 15 | Value for the temporary scroll register |
| vram_rdata | input | 8 | Read data, valid one cycle after its address |
| vram_addr | output | 14 | Video memory address |
| vram_rd | output | 1 | Read request for `vram_addr` |
| tile_num | output | 8 | Tile number of the delivered tile |
| tile_attr | output | 2 | Palette bits of the delivered tile |
| tile_lo | output | 8 | Low pattern plane byte |
| tile_hi | output | 8 | High pattern plane byte |
| tile_valid | output | 1 | One-cycle strobe for the tile bundle |
| scroll_q | output | 15 | Current scroll register |

## Verification
The bench builds the block with its default parameters: 240 visible lines, pre-render line 261, a 14-bit address, 8-bit data and two nametable fetches at the end of the line. Because the bench drives the dot and line counters itself, it can jump straight to dot 255, dot 256, the pre-render copy window and the end-of-line slots without running whole frames. It can likewise seed the scroll register with chosen wrap values (coarse X 31, coarse Y 29 and 31, fine Y 7) by way of the two copy windows.

// File: rtl/bgf_pkg.sv
package bgf_pkg;

   typedef enum logic [2:0] {
      SL_NT_A = 3'd0,
      SL_NT_R = 3'd1,
      SL_AT_A = 3'd2,
      SL_AT_R = 3'd3,
      SL_LO_A = 3'd4,
      SL_LO_R = 3'd5,
      SL_HI_A = 3'd6,
      SL_HI_R = 3'd7
   } slot_e;

   typedef struct packed {
      logic [2:0] fine_y;
      logic       nt_v;
      logic       nt_h;
      logic [4:0] coarse_y;
      logic [4:0] coarse_x;
   } scroll_t;

   typedef struct packed {
      logic nt_addr;
      logic at_addr;
      logic lo_addr;
      logic hi_addr;
      logic nt_cap;
      logic at_cap;
      logic lo_cap;
      logic hi_cap;
      logic inc_x;
      logic inc_y;
      logic copy_h;
      logic copy_v;
   } ctl_t;

   localparam logic [14:0] H_MASK = 15'h041F;
   localparam logic [14:0] V_MASK = 15'h7BE0;

endpackage

// File: rtl/bgf_slot_decode.sv
module bgf_slot_decode
   import bgf_pkg::*;
#(
   parameter int DOT_W     = 9,
   parameter int LINE_W    = 9,
   parameter int VIS_LINES = 240,
   parameter int PRE_LINE  = 261,
   parameter int TAIL_NT   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DOT_W-1:0]  dot,
   input  logic [LINE_W-1:0] line,
   input  logic              render_en,
   output logic              active,
   output ctl_t              ctl
);

   localparam int MAIN_END = 256;
   localparam int PREF_BEG = 320;
   localparam int TAIL_BEG = 336;
   localparam int TAIL_END = 340;
   localparam int YSTEP_DOT = MAIN_END - 1;
   localparam int VCOPY_BEG = 279;
   localparam int VCOPY_END = 303;

   slot_e slot;
   logic  in_main, in_ntat, in_pref, in_tail, full, nt_zone;
   logic  tail_a, tail_r;

   assign slot    = slot_e'(dot[2:0]);
   assign active  = render_en && ((int'(line) < VIS_LINES) || (int'(line) == PRE_LINE));
   assign in_main = int'(dot) < MAIN_END;
   assign in_ntat = (int'(dot) >= MAIN_END) && (int'(dot) < PREF_BEG);
   assign in_pref = (int'(dot) >= PREF_BEG) && (int'(dot) < TAIL_BEG);
   assign in_tail = (int'(dot) >= TAIL_BEG) && (int'(dot) < TAIL_END);
   assign full    = in_main || in_pref;
   assign nt_zone = full || in_ntat;

   generate
      if (TAIL_NT == 2) begin : g_tail_two
         assign tail_a = in_tail && ((slot == SL_NT_A) || (slot == SL_AT_A));
         assign tail_r = in_tail && ((slot == SL_NT_R) || (slot == SL_AT_R));
      end else begin : g_tail_one
         assign tail_a = in_tail && (slot == SL_NT_A);
         assign tail_r = in_tail && (slot == SL_NT_R);
      end
   endgenerate

   always_comb begin
      ctl         = '0;
      ctl.nt_addr = active && ((nt_zone && slot == SL_NT_A) || tail_a);
      ctl.nt_cap  = active && ((nt_zone && slot == SL_NT_R) || tail_r);
      ctl.at_addr = active && nt_zone && slot == SL_AT_A;
      ctl.at_cap  = active && nt_zone && slot == SL_AT_R;
      ctl.lo_addr = active && full && slot == SL_LO_A;
      ctl.lo_cap  = active && full && slot == SL_LO_R;
      ctl.hi_addr = active && full && slot == SL_HI_A;
      ctl.hi_cap  = active && full && slot == SL_HI_R;
      ctl.inc_y   = active && int'(dot) == YSTEP_DOT;
      ctl.inc_x   = active && full && slot == SL_HI_R && int'(dot) != YSTEP_DOT;
      ctl.copy_h  = active && int'(dot) == MAIN_END;
      ctl.copy_v  = active && int'(line) == PRE_LINE &&
                    int'(dot) >= VCOPY_BEG && int'(dot) <= VCOPY_END;
   end

   // R10
   addr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.nt_addr, ctl.at_addr, ctl.lo_addr, ctl.hi_addr}));

   // R10
   no_plane_mid_chk: assert property (@(posedge clk) disable iff (rst)
      (in_ntat || in_tail) |-> !(ctl.lo_addr || ctl.hi_addr));

endmodule

// File: rtl/bgf_scroll_reg.sv
module bgf_scroll_reg
   import bgf_pkg::*;
#(
   parameter int SCR_W = 15
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_x,
   input  logic             inc_y,
   input  logic             copy_h,
   input  logic             copy_v,
   input  logic [SCR_W-1:0] tmp_q,
   output logic [SCR_W-1:0] scroll_q
);

   scroll_t cur, nxt_x, nxt_y;

   assign cur = scroll_t'(scroll_q);

   always_comb begin
      nxt_x = cur;
      if (cur.coarse_x == 5'd31) begin
         nxt_x.coarse_x = 5'd0;
         nxt_x.nt_h     = ~cur.nt_h;
      end else begin
         nxt_x.coarse_x = cur.coarse_x + 5'd1;
      end
   end

   always_comb begin
      nxt_y = cur;
      if (cur.fine_y != 3'd7) begin
         nxt_y.fine_y = cur.fine_y + 3'd1;
      end else begin
         nxt_y.fine_y = 3'd0;
         if (cur.coarse_y == 5'd29) begin
            nxt_y.coarse_y = 5'd0;
            nxt_y.nt_v     = ~cur.nt_v;
         end else if (cur.coarse_y == 5'd31) begin
            nxt_y.coarse_y = 5'd0;
         end else begin
            nxt_y.coarse_y = cur.coarse_y + 5'd1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         scroll_q <= '0;
      end else if (inc_y) begin
         scroll_q <= SCR_W'(nxt_y);
      end else if (inc_x) begin
         scroll_q <= SCR_W'(nxt_x);
      end else if (copy_h) begin
         scroll_q <= (scroll_q & ~H_MASK) | (tmp_q & H_MASK);
      end else if (copy_v) begin
         scroll_q <= (scroll_q & ~V_MASK) | (tmp_q & V_MASK);
      end
   end

   // R11
   quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(inc_x || inc_y || copy_h || copy_v) |=> $stable(scroll_q));

   // R6
   x_step_chk: assert property (@(posedge clk) disable iff (rst)
      (inc_x && scroll_q[4:0] != 5'd31) |=>
         (scroll_q[4:0] == $past(scroll_q[4:0]) + 5'd1) && $stable(scroll_q[14:5]));

   // R6
   x_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (inc_x && scroll_q[4:0] == 5'd31) |=>
         (scroll_q[4:0] == 5'd0) && (scroll_q[10] != $past(scroll_q[10])));

   // R7
   y_fine_chk: assert property (@(posedge clk) disable iff (rst)
      (inc_y && scroll_q[14:12] != 3'd7) |=>
         (scroll_q[14:12] == $past(scroll_q[14:12]) + 3'd1) && $stable(scroll_q[11:0]));

   // R8
   copy_h_chk: assert property (@(posedge clk) disable iff (rst)
      (copy_h && !inc_x && !inc_y) |=> ((scroll_q & H_MASK) == ($past(tmp_q) & H_MASK)));

endmodule

// File: rtl/bgf_fetch_path.sv
module bgf_fetch_path
   import bgf_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8,
   parameter int SCR_W  = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  ctl_t              ctl,
   input  logic [SCR_W-1:0]  scroll_q,
   input  logic              pat_base_sel,
   input  logic [DATA_W-1:0] vram_rdata,
   output logic [ADDR_W-1:0] vram_addr,
   output logic              vram_rd,
   output logic [DATA_W-1:0] tile_num,
   output logic [1:0]        tile_attr,
   output logic [DATA_W-1:0] tile_lo,
   output logic [DATA_W-1:0] tile_hi,
   output logic              tile_valid
);

   localparam int BASE_W = 14;

   scroll_t           sc;
   logic [BASE_W-1:0] addr14;
   logic [DATA_W-1:0] nt_lat, lo_lat;
   logic [1:0]        at_lat;
   logic [2:0]        at_shift;
   logic [DATA_W-1:0] at_shifted;

   assign sc = scroll_t'(scroll_q);

   always_comb begin
      addr14 = '0;
      if (ctl.nt_addr) begin
         addr14 = {2'b10, scroll_q[11:0]};
      end else if (ctl.at_addr) begin
         addr14 = {2'b10, sc.nt_v, sc.nt_h, 4'b1111, sc.coarse_y[4:2], sc.coarse_x[4:2]};
      end else if (ctl.lo_addr || ctl.hi_addr) begin
         addr14 = {1'b0, pat_base_sel, nt_lat[7:0], ctl.hi_addr, sc.fine_y};
      end
   end

   generate
      if (ADDR_W == BASE_W) begin : g_addr_exact
         assign vram_addr = addr14;
      end else begin : g_addr_pad
         assign vram_addr = {{(ADDR_W-BASE_W){1'b0}}, addr14};
      end
   endgenerate

   assign vram_rd    = ctl.nt_addr || ctl.at_addr || ctl.lo_addr || ctl.hi_addr;
   assign at_shift   = {sc.coarse_y[1], sc.coarse_x[1], 1'b0};
   assign at_shifted = vram_rdata >> at_shift;

   always_ff @(posedge clk) begin
      if (rst) begin
         nt_lat     <= '0;
         at_lat     <= '0;
         lo_lat     <= '0;
         tile_num   <= '0;
         tile_attr  <= '0;
         tile_lo    <= '0;
         tile_hi    <= '0;
         tile_valid <= 1'b0;
      end else begin
         if (ctl.nt_cap) nt_lat <= vram_rdata;
         if (ctl.at_cap) at_lat <= at_shifted[1:0];
         if (ctl.lo_cap) lo_lat <= vram_rdata;
         tile_valid <= ctl.hi_cap;
         if (ctl.hi_cap) begin
            tile_num  <= nt_lat;
            tile_attr <= at_lat;
            tile_lo   <= lo_lat;
            tile_hi   <= vram_rdata;
         end
      end
   end

   // R12
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      tile_valid |=> !tile_valid);

   // R12
   valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
      tile_valid |-> $past(ctl.hi_cap));

   // R12
   valid_hi_byte_chk: assert property (@(posedge clk) disable iff (rst)
      ctl.hi_cap |=> (tile_hi == $past(vram_rdata)));

endmodule

// File: rtl/bg_tile_fetcher.sv
module bg_tile_fetcher
   import bgf_pkg::*;
#(
   parameter int DOT_W     = 9,
   parameter int LINE_W    = 9,
   parameter int VIS_LINES = 240,
   parameter int PRE_LINE  = 261,
   parameter int ADDR_W    = 14,
   parameter int DATA_W    = 8,
   parameter int TAIL_NT   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DOT_W-1:0]  dot,
   input  logic [LINE_W-1:0] line,
   input  logic              render_en,
   input  logic              pat_base_sel,
   input  logic              tmp_wr_en,
   input  logic [14:0]       tmp_wr_data,
   input  logic [DATA_W-1:0] vram_rdata,
   output logic [ADDR_W-1:0] vram_addr,
   output logic              vram_rd,
   output logic [DATA_W-1:0] tile_num,
   output logic [1:0]        tile_attr,
   output logic [DATA_W-1:0] tile_lo,
   output logic [DATA_W-1:0] tile_hi,
   output logic              tile_valid,
   output logic [14:0]       scroll_q
);

   localparam int SCR_W = $bits(scroll_t);

   generate
      if (DOT_W < 9) begin : g_bad_dot
         $error("DOT_W must hold dot 340");
      end
      if ((1 << LINE_W) <= PRE_LINE) begin : g_bad_line
         $error("LINE_W too narrow for PRE_LINE");
      end
      if (VIS_LINES >= PRE_LINE) begin : g_bad_vis
         $error("VIS_LINES must precede PRE_LINE");
      end
      if (ADDR_W < 14) begin : g_bad_addr
         $error("ADDR_W must be at least 14");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("DATA_W must be 8");
      end
      if (TAIL_NT != 1 && TAIL_NT != 2) begin : g_bad_tail
         $error("TAIL_NT must be 1 or 2");
      end
   endgenerate

   ctl_t             ctl;
   logic             active;
   logic [SCR_W-1:0] tmp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tmp_q <= '0;
      end else if (tmp_wr_en) begin
         tmp_q <= tmp_wr_data;
      end
   end

   bgf_slot_decode #(
      .DOT_W     (DOT_W),
      .LINE_W    (LINE_W),
      .VIS_LINES (VIS_LINES),
      .PRE_LINE  (PRE_LINE),
      .TAIL_NT   (TAIL_NT)
   ) u_decode (
      .clk       (clk),
      .rst       (rst),
      .dot       (dot),
      .line      (line),
      .render_en (render_en),
      .active    (active),
      .ctl       (ctl)
   );

   bgf_scroll_reg #(
      .SCR_W (SCR_W)
   ) u_scroll (
      .clk      (clk),
      .rst      (rst),
      .inc_x    (ctl.inc_x),
      .inc_y    (ctl.inc_y),
      .copy_h   (ctl.copy_h),
      .copy_v   (ctl.copy_v),
      .tmp_q    (tmp_q),
      .scroll_q (scroll_q)
   );

   bgf_fetch_path #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SCR_W  (SCR_W)
   ) u_fetch (
      .clk          (clk),
      .rst          (rst),
      .ctl          (ctl),
      .scroll_q     (scroll_q),
      .pat_base_sel (pat_base_sel),
      .vram_rdata   (vram_rdata),
      .vram_addr    (vram_addr),
      .vram_rd      (vram_rd),
      .tile_num     (tile_num),
      .tile_attr    (tile_attr),
      .tile_lo      (tile_lo),
      .tile_hi      (tile_hi),
      .tile_valid   (tile_valid)
   );

   // R11
   idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
      !active |-> !vram_rd);

   // R11
   idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (!active && !$past(active)) |-> !tile_valid);

endmodule

// File: tb/bg_tile_fetcher_tb.sv
`timescale 1ns/1ps
module bg_tile_fetcher_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic [8:0]  dot;
   logic [8:0]  line;
   logic        render_en;
   logic        pat_base_sel;
   logic        tmp_wr_en;
   logic [14:0] tmp_wr_data;
   logic [7:0]  vram_rdata;
   logic [13:0] vram_addr;
   logic        vram_rd;
   logic [7:0]  tile_num;
   logic [1:0]  tile_attr;
   logic [7:0]  tile_lo;
   logic [7:0]  tile_hi;
   logic        tile_valid;
   logic [14:0] scroll_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [13:0] a_seen;
   logic        rd_seen;
   logic [14:0] ev;

   always #2.5 clk = ~clk;

   bg_tile_fetcher u_dut (
      .clk(clk), .rst(rst), .dot(dot), .line(line), .render_en(render_en),
      .pat_base_sel(pat_base_sel), .tmp_wr_en(tmp_wr_en), .tmp_wr_data(tmp_wr_data),
      .vram_rdata(vram_rdata), .vram_addr(vram_addr), .vram_rd(vram_rd),
      .tile_num(tile_num), .tile_attr(tile_attr), .tile_lo(tile_lo),
      .tile_hi(tile_hi), .tile_valid(tile_valid), .scroll_q(scroll_q)
   );

   function automatic logic [7:0] vmem(input logic [13:0] a);
      return a[7:0] ^ {a[13:8], 2'b01};
   endfunction

   always @(posedge clk) if (vram_rd) vram_rdata <= vmem(vram_addr);

   function automatic logic [14:0] step_x(input logic [14:0] v);
      logic [14:0] r = v;
      if (v[4:0] == 5'd31) begin r[4:0] = 0; r[10] = ~v[10]; end
      else r[4:0] = v[4:0] + 5'd1;
      return r;
   endfunction

   function automatic logic [14:0] step_y(input logic [14:0] v);
      logic [14:0] r = v;
      if (v[14:12] != 3'd7) r[14:12] = v[14:12] + 3'd1;
      else begin
         r[14:12] = 0;
         if (v[9:5] == 5'd29) begin r[9:5] = 0; r[11] = ~v[11]; end
         else if (v[9:5] == 5'd31) r[9:5] = 0;
         else r[9:5] = v[9:5] + 5'd1;
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int d, input int l);
      @(negedge clk);
      dot = 9'(d); line = 9'(l);
      #1;
      a_seen = vram_addr; rd_seen = vram_rd;
      @(posedge clk); #1;
   endtask

   task automatic wr_tmp(input logic [14:0] v);
      @(negedge clk);
      dot = 9'd340; tmp_wr_en = 1'b1; tmp_wr_data = v;
      @(posedge clk); #1;
      tmp_wr_en = 1'b0;
   endtask

   task automatic load_scroll(input logic [14:0] v);
      wr_tmp(v);
      cyc(256, 261);
      cyc(279, 261);
      ev = v;
      chk("R9 load via copies", scroll_q, v);
   endtask

   task automatic run_group(input int d0, input int l, input string req);
      logic [13:0] nta, ata, pla;
      logic [7:0]  tn, ab, lo, hi;
      logic [2:0]  sh;
      nta = {2'b10, ev[11:0]};
      ata = 14'h23C0 | {2'b00, ev[11:10], 10'd0} | {8'd0, ev[9:7], 3'd0} | {11'd0, ev[4:2]};
      tn  = vmem(nta);
      pla = {1'b0, pat_base_sel, tn, 1'b0, ev[14:12]};
      ab  = vmem(ata);
      sh  = {ev[6], ev[1], 1'b0};
      ab  = ab >> sh;
      lo  = vmem(pla);
      hi  = vmem(pla | 14'h8);
      for (int k = 0; k < 8; k++) begin
         cyc(d0 + k, l);
         case (k)
            0: chk("R2 nametable addr", {rd_seen, a_seen}, {1'b1, nta});
            2: chk("R3 attribute addr", {rd_seen, a_seen}, {1'b1, ata});
            4: chk("R5 low plane addr", {rd_seen, a_seen}, {1'b1, pla});
            6: chk("R5 high plane addr", {rd_seen, a_seen}, {1'b1, pla | 14'h8});
            default: chk("R2 read slot no request", rd_seen, 1'b0);
         endcase
         if (k < 7) chk("R12 no early valid", tile_valid, 1'b0);
      end
      chk("R12 valid strobe", tile_valid, 1'b1);
      chk("R12 tile number", tile_num, tn);
      chk("R4 attribute bits", tile_attr, ab[1:0]);
      chk("R12 low plane", tile_lo, lo);
      chk("R12 high plane", tile_hi, hi);
      ev = (d0 + 7 == 255) ? step_y(ev) : step_x(ev);
      chk(req, scroll_q, ev);
   endtask

   task automatic t_reset;
      chk("R1 scroll after reset", scroll_q, 15'd0);
      chk("R1 valid after reset", tile_valid, 1'b0);
      chk("R1 no request during reset", vram_rd, 1'b0);
   endtask

   task automatic t_groups;
      pat_base_sel = 1'b1;
      load_scroll({3'd3, 2'b10, 5'd13, 5'd6});
      run_group(8, 10, "R6 coarse x step");
      cyc(16, 10);
      chk("R12 valid one cycle", tile_valid, 1'b0);
      pat_base_sel = 1'b0;
      load_scroll({3'd5, 2'b01, 5'd6, 5'd1});
      run_group(40, 100, "R6 coarse x step b");
      load_scroll({3'd0, 2'b00, 5'd7, 5'd18});
      run_group(0, 0, "R6 coarse x step c");
   endtask

   task automatic t_xwrap;
      pat_base_sel = 1'b1;
      load_scroll({3'd2, 2'b00, 5'd4, 5'd31});
      run_group(64, 5, "R6 coarse x wrap toggles bit 10");
      load_scroll({3'd2, 2'b01, 5'd4, 5'd31});
      run_group(64, 5, "R6 coarse x wrap toggles bit 10 back");
   endtask

   task automatic t_ystep;
      load_scroll({3'd2, 2'b00, 5'd10, 5'd3});
      run_group(248, 20, "R7 fine y step");
      load_scroll({3'd7, 2'b00, 5'd29, 5'd3});
      run_group(248, 20, "R7 coarse y 29 wraps with toggle");
      load_scroll({3'd7, 2'b10, 5'd31, 5'd3});
      run_group(248, 20, "R7 coarse y 31 wraps no toggle");
      load_scroll({3'd7, 2'b00, 5'd5, 5'd3});
      run_group(248, 20, "R7 coarse y step");
   endtask

   task automatic t_copy_h_mid;
      logic [14:0] t;
      load_scroll(15'h1234);
      t = 15'h6BDF;
      wr_tmp(t);
      for (int d = 256; d < 264; d++) begin
         cyc(d, 30);
         if (d == 256) begin
            ev = (ev & ~15'h041F) | (t & 15'h041F);
            chk("R8 horizontal copy", scroll_q, ev);
            chk("R10 nametable at 256", {rd_seen, a_seen}, {1'b1, 2'b10, 12'h234});
         end
         if (d == 258) chk("R10 attribute at 258", rd_seen, 1'b1);
         if (d >= 260) chk("R10 no plane fetch 260-263", rd_seen, 1'b0);
         chk("R10 no valid in 256-319", tile_valid, 1'b0);
      end
      chk("R10 scroll holds in 257-263", scroll_q, ev);
   endtask

   task automatic t_copy_v;
      logic [14:0] t;
      load_scroll(15'h0000);
      t = 15'h7FFF;
      wr_tmp(t);
      cyc(280, 30);
      chk("R9 no vertical copy on visible line", scroll_q, 15'h0000);
      cyc(304, 261);
      chk("R9 no vertical copy at dot 304", scroll_q, 15'h0000);
      cyc(303, 261);
      chk("R9 vertical copy at dot 303", scroll_q, t & 15'h7BE0);
   endtask

   task automatic t_tail;
      load_scroll(15'h2ABC);
      for (int d = 336; d <= 340; d++) begin
         cyc(d, 50);
         if (d == 336 || d == 338)
            chk("R10 tail nametable fetch", {rd_seen, a_seen}, {1'b1, 2'b10, 12'hABC});
         else
            chk("R10 tail read or idle", rd_seen, 1'b0);
         chk("R10 tail no valid", tile_valid, 1'b0);
      end
      chk("R10 tail scroll held", scroll_q, 15'h2ABC);
   endtask

   task automatic t_prefetch;
      load_scroll({3'd1, 2'b00, 5'd0, 5'd0});
      pat_base_sel = 1'b1;
      run_group(320, 261, "R10 prefetch tile steps x");
      run_group(328, 261, "R10 second prefetch tile");
   endtask

   task automatic t_disabled;
      load_scroll(15'h3456);
      render_en = 1'b0;
      for (int d = 248; d < 257; d++) begin
         cyc(d, 10);
         chk("R11 no request when disabled", rd_seen, 1'b0);
         chk("R11 no valid when disabled", tile_valid, 1'b0);
      end
      chk("R11 scroll held when disabled", scroll_q, 15'h3456);
      render_en = 1'b1;
      for (int d = 248; d < 257; d++) begin
         cyc(d, 245);
         chk("R11 no request in vblank", rd_seen, 1'b0);
         chk("R11 no valid in vblank", tile_valid, 1'b0);
      end
      chk("R11 scroll held in vblank", scroll_q, 15'h3456);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; dot = 9'd340; line = 9'd0; render_en = 1'b0;
      pat_base_sel = 1'b0; tmp_wr_en = 1'b0; tmp_wr_data = '0; vram_rdata = '0;
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst = 1'b0; render_en = 1'b1;
      t_groups();
      t_xwrap();
      t_ystep();
      t_copy_h_mid();
      t_copy_v();
      t_tail();
      t_prefetch();
      t_disabled();
      finish_run();
   end

endmodule